// File: doc/BRIEF.md
# Byte Program Sequencer

This block performs one byte-program operation on a byte-wide non-volatile array model after a command decoder hands it a start pulse with a target address and data byte. It first compares the address against a per-block protection mask. If the target block is protected, the request is dropped quietly. Otherwise the block reads the old byte and forms the new value by ANDing the old byte with the requested byte, so a program can only clear bits. It writes that value through a simple synchronous array port, waits a fixed number of clock cycles to stand in for the program time, and then reads the location back to verify it.

While the operation runs, and while a failure is pending, the block raises `stat_sel`. The surrounding read path then returns `stat` in place of array data. A successful verify returns the block to array-read mode without any further command. A failed verify latches an error that stays until `reset_req` is applied. That request takes effect only after an abort interval.

The array is 128K bytes, split into 8 uniform 16 KB blocks. The array port reads synchronously: read data is valid in the cycle after `arr_rd`.

Top module: `byte_prog_seq`

## Requirements
- R1: The block index is `addr[16:14]`. If `prot` has the bit for that index set when an idle block sees `start`, no array read or write happens, `busy` and `err` stay low, and `done` is high for exactly the one cycle after the start.
- R2: After an unprotected program, the location holds the bitwise AND of its previous content and `wdata`. A bit that is 0 never becomes 1.
- R3: An accepted unprotected start raises `busy` in the next cycle and keeps it high for exactly PROG_CYCLES+5 cycles.
- R4: `stat_sel` is high whenever `busy` or `err` is high. While it is high, `stat[7]` is the inverse of bit 7 of the byte being programmed, `stat[5]` equals `err`, and `stat[4:0]` are 0. While `stat_sel` is low, `stat` is 0.
- R5: `stat[6]` inverts after each clock edge at which both `rd_stat` and `stat_sel` are high, and holds its value after every other edge.
- R6: When the read-back matches the expected value, `done` is high for one cycle as `busy` drops, and `err` and `stat_sel` stay low.
- R7: When the read-back differs, `err` rises together with `done` and stays high for as many cycles as `reset_req` stays low.
- R8: A `reset_req` sampled while the error is latched keeps `err` and `stat_sel` high for ABORT_CYCLES more cycles, after which both drop and a new start is accepted.
- R9: `start` is ignored while `busy` or `err` is high, and `reset_req` has no effect outside the error state. The observable effect is that the array content and the outputs are unchanged.
- R10: Each unprotected program makes exactly one array write, carrying the ANDed byte, with one array read before it and one array read after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse from the command decoder |
| addr | input | 17 | Target byte address |
| wdata | input | 8 | Byte to program |
| prot | input | 8 | Per-block protection mask, bit i for block i |
| reset_req | input | 1 | Clears a latched error after the abort interval |
| rd_stat | input | 1 | A bus read of the status byte is taking place |
| arr_rd | output | 1 | Array read strobe |
| arr_wr | output | 1 | Array write strobe |
| arr_addr | output | 17 | Array address |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data, valid the cycle after `arr_rd` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Latched verify failure |
| stat_sel | output | 1 | Bus reads should return `stat` |
| stat | output | 8 | Status byte |

## Verification
If the sequencer's state register goes wrong, the fault shows at the ports within one cycle as a wrong `busy`, `stat_sel` or `err` level. An off-by-one in the program or abort counter moves the falling edge of `busy` or `err` by a cycle, and the bench sees that in the cycle it happens. A merge or protection fault shows up as a wrong array write count, or as a byte in the array that differs from the AND rule, when the operation ends. A wrong toggle or status encoding appears on `stat` during the very status read that exposes it.

// File: rtl/byte_prog_seq.sv
module byte_prog_seq #(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int BLK_W        = 3,
  parameter int PROG_CYCLES  = 16,
  parameter int ABORT_CYCLES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [(1<<BLK_W)-1:0]  prot,
  input  logic                   reset_req,
  input  logic                   rd_stat,
  output logic                   arr_rd,
  output logic                   arr_wr,
  output logic [ADDR_W-1:0]      arr_addr,
  output logic [DATA_W-1:0]      arr_wdata,
  input  logic [DATA_W-1:0]      arr_rdata,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic                   stat_sel,
  output logic [DATA_W-1:0]      stat
);

  localparam int LONGEST = (PROG_CYCLES > ABORT_CYCLES) ? PROG_CYCLES : ABORT_CYCLES;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RD, S_MRG, S_WR, S_WAIT, S_VRD, S_VCHK, S_ERR, S_ABT
  } st_t;

  st_t               st;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic [DATA_W-1:0] m_q;
  logic [CNT_W-1:0]  cnt;
  logic              tog;
  logic              hit;

  assign hit = prot[addr[ADDR_W-1 -: BLK_W]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      a_q  <= '0;
      d_q  <= '0;
      m_q  <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (hit) done <= 1'b1;
          else begin
            a_q <= addr;
            d_q <= wdata;
            st  <= S_RD;
          end
        end
        S_RD:   st <= S_MRG;
        S_MRG: begin
          m_q <= arr_rdata & d_q;
          st  <= S_WR;
        end
        S_WR: begin
          cnt <= CNT_W'(PROG_CYCLES - 1);
          st  <= S_WAIT;
        end
        S_WAIT: if (cnt == '0) st <= S_VRD;
                else cnt <= cnt - 1'b1;
        S_VRD:  st <= S_VCHK;
        S_VCHK: begin
          done <= 1'b1;
          st   <= (arr_rdata == m_q) ? S_IDLE : S_ERR;
        end
        S_ERR: if (reset_req) begin
          cnt <= CNT_W'(ABORT_CYCLES - 1);
          st  <= S_ABT;
        end
        S_ABT:  if (cnt == '0) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tog <= 1'b0;
    else if (rd_stat && stat_sel) tog <= ~tog;
  end

  assign busy      = (st == S_RD) || (st == S_MRG) || (st == S_WR) ||
                     (st == S_WAIT) || (st == S_VRD) || (st == S_VCHK);
  assign err       = (st == S_ERR) || (st == S_ABT);
  assign stat_sel  = busy || err;
  assign arr_rd    = (st == S_RD) || (st == S_VRD);
  assign arr_wr    = (st == S_WR);
  assign arr_addr  = a_q;
  assign arr_wdata = m_q;
  assign stat      = stat_sel ? {~d_q[DATA_W-1], tog, err, {(DATA_W-3){1'b0}}} : '0;

endmodule

// File: rtl/byte_prog_seq_chk.sv
module byte_prog_seq_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int BLK_W  = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic [ADDR_W-1:0]     addr,
  input logic [(1<<BLK_W)-1:0] prot,
  input logic                  rd_stat,
  input logic                  arr_rd,
  input logic                  arr_wr,
  input logic                  busy,
  input logic                  done,
  input logic                  err,
  input logic                  stat_sel,
  input logic [DATA_W-1:0]     stat
);

  logic hit;
  logic quiet;
  assign hit   = prot[addr[ADDR_W-1 -: BLK_W]];
  assign quiet = !busy && !err;

  a_r1_prot_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    start && quiet && hit |=> done && !busy && !err && !arr_wr);

  a_r3_busy_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    start && quiet && !hit |=> busy && !done);

  a_r5_toggle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    stat_sel && $past(stat_sel) && !$past(rd_stat) |-> $stable(stat[DATA_W-2]));

  a_r5_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    stat_sel && rd_stat |=> stat_sel && (stat[DATA_W-2] != $past(stat[DATA_W-2])));

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done && $past(busy));

  a_r8_err_exit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> !busy && !done && !stat_sel);

  a_r10_write_inside: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr |-> busy && !arr_rd && $past(busy));

  a_r10_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr |=> !arr_wr);

endmodule

bind byte_prog_seq byte_prog_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .prot(prot),
  .rd_stat(rd_stat), .arr_rd(arr_rd), .arr_wr(arr_wr), .busy(busy),
  .done(done), .err(err), .stat_sel(stat_sel), .stat(stat)
);

// File: tb/byte_prog_seq_test.sv
module byte_prog_seq_test;
  localparam int PC    = 12;
  localparam int AC    = 6;
  localparam int STUCK = 'h0ABCD;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, reset_req, rd_stat;
  logic [16:0] addr;
  logic [7:0]  wdata, prot;
  logic        arr_rd, arr_wr;
  logic [16:0] arr_addr;
  logic [7:0]  arr_wdata;
  logic [7:0]  arr_rdata;
  logic        busy, done, err, stat_sel;
  logic [7:0]  stat;

  byte_prog_seq #(.PROG_CYCLES(PC), .ABORT_CYCLES(AC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .wdata(wdata),
    .prot(prot), .reset_req(reset_req), .rd_stat(rd_stat),
    .arr_rd(arr_rd), .arr_wr(arr_wr), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .busy(busy), .done(done),
    .err(err), .stat_sel(stat_sel), .stat(stat));

  int vecs = 0, bad = 0, cyc = 0, nwr = 0, nrd = 0;
  logic [7:0] mem  [int];
  logic [7:0] rmem [int];

  function automatic logic [7:0] peek(int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction
  function automatic logic [7:0] rpeek(int a);
    return rmem.exists(a) ? rmem[a] : 8'hFF;
  endfunction

  task automatic chk(bit ok, string tag, int got, int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // array model: synchronous read, one location ignores writes
  always @(posedge clk) begin
    if (arr_rd) begin arr_rdata <= peek(int'(arr_addr)); nrd++; end
    if (arr_wr) begin
      nwr++;
      if (int'(arr_addr) != STUCK) mem[int'(arr_addr)] = arr_wdata;
    end
  end

  // reference model
  int   m_b = 0, m_ab = 0;
  bit   m_err = 0, m_done = 0, m_tog = 0, m_fail = 0, m_b7 = 1;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_b = 0; m_ab = 0; m_err = 0; m_done = 0; m_tog = 0; m_b7 = 1;
    end else begin
      if (rd_stat && ((m_b > 0) || m_err)) m_tog = ~m_tog;
      m_done = 0;
      if (m_b > 0) begin
        m_b--;
        if (m_b == 0) begin m_done = 1; if (m_fail) m_err = 1; end
      end else if (m_ab > 0) begin
        m_ab--;
        if (m_ab == 0) m_err = 0;
      end else if (m_err) begin
        if (reset_req) m_ab = AC;
      end else if (start) begin
        if (prot[addr[16:14]]) m_done = 1;
        else begin
          logic [7:0] o, n;
          o = rpeek(int'(addr));
          n = o & wdata;
          m_fail = (int'(addr) == STUCK) && (n != o);
          if (int'(addr) != STUCK) rmem[int'(addr)] = n;
          m_b  = 5 + PC;
          m_b7 = ~wdata[7];
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      logic sel;
      sel = (m_b > 0) || m_err;
      chk(busy == (m_b > 0), "R3 busy", busy, m_b > 0);
      chk(done == m_done, "R6 done", done, m_done);
      chk(err == m_err, "R7 err", err, m_err);
      chk(stat_sel == sel, "R4 stat_sel", stat_sel, sel);
      chk({stat[7], stat[5:0]} == (sel ? {m_b7, m_err, 5'b0} : 7'b0), "R4 stat",
          stat, sel ? {m_b7, m_tog, m_err, 5'b0} : 8'h00);
      chk(stat[6] == (sel & m_tog), "R5 toggle bit", stat[6], sel & m_tog);
    end
    if (cyc == 150000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  task automatic do_op(int a, logic [7:0] d);
    @(negedge clk);
    nwr = 0; nrd = 0;
    addr = 17'(a); wdata = d; start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0;
  endtask

  initial begin
    rst_n = 0; start = 0; reset_req = 0; rd_stat = 0;
    addr = '0; wdata = '0; prot = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && stat == 8'h00 && !arr_wr && !arr_rd,
        "R4 reset state", {busy, done, err, arr_wr}, 0);
    rst_n = 1;

    do_op('h00123, 8'hA5);
    chk(peek('h123) == 8'hA5, "R2 first program", peek('h123), 8'hA5);
    chk(nwr == 1 && nrd == 2, "R10 access count", nwr * 16 + nrd, 16 + 2);
    do_op('h00123, 8'h5A);
    chk(peek('h123) == 8'h00, "R2 and rule", peek('h123), 8'h00);

    prot = 8'h08;
    do_op('h0C010, 8'h00);
    chk(peek('h0C010) == 8'hFF, "R1 protected byte", peek('h0C010), 8'hFF);
    chk(nwr == 0 && nrd == 0, "R1 no access", nwr + nrd, 0);

    prot = 8'h80;
    do_op('h1FFFF, 8'h00);
    chk(peek('h1FFFF) == 8'hFF, "R1 top block", peek('h1FFFF), 8'hFF);
    do_op('h1BFFF, 8'h3C);
    chk(peek('h1BFFF) == 8'h3C, "R1 neighbour block", peek('h1BFFF), 8'h3C);
    do_op('h00000, 8'hC3);
    chk(peek('h0) == 8'hC3, "R2 block zero", peek('h0), 8'hC3);

    // status reads during busy
    @(negedge clk); addr = 17'h200; wdata = 8'h7E; start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 4; i++) begin
      rd_stat = 1; @(negedge clk); rd_stat = 0; @(negedge clk); @(negedge clk);
    end
    rd_stat = 1; @(negedge clk); rd_stat = 0;
    // start and reset_req during busy
    addr = 17'h301; wdata = 8'h00; start = 1; reset_req = 1;
    @(negedge clk); start = 0; reset_req = 0;
    while (!done) @(negedge clk);
    chk(peek('h200) == 8'h7E, "R2 status run", peek('h200), 8'h7E);
    chk(peek('h301) == 8'hFF, "R9 start while busy", peek('h301), 8'hFF);

    pulse(reset_req);
    repeat (2) @(negedge clk);
    chk(!err && !stat_sel, "R9 reset idle", err, 0);

    // verify failure
    do_op(STUCK, 8'h0F);
    chk(err == 1, "R7 err raised", err, 1);
    repeat (20) @(negedge clk);
    chk(err == 1, "R7 err held", err, 1);
    @(negedge clk); addr = 17'h400; wdata = 8'h00; start = 1;
    @(negedge clk); start = 0;
    pulse(rd_stat);
    repeat (PC + 8) @(negedge clk);
    chk(peek('h400) == 8'hFF, "R9 start in error", peek('h400), 8'hFF);
    pulse(reset_req);
    repeat (AC - 1) @(negedge clk);
    chk(err == 1, "R8 abort interval", err, 1);
    repeat (2) @(negedge clk);
    chk(err == 0, "R8 error cleared", err, 0);
    do_op('h400, 8'h99);
    chk(peek('h400) == 8'h99, "R8 start after abort", peek('h400), 8'h99);

    do_op(STUCK, 8'hFF);
    chk(err == 0, "R6 no change passes verify", err, 0);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule